// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns one active-low external power-on reset into a staged release of three internal resets. The first is an internal power-on reset, then a hard reset, then a soft reset. A qualified release of the external pin starts the sequence. An internal counter waits out a fixed delay. A second counter stands in for the time a PLL needs to lock, and a third times the hard and soft releases from that lock point. Lock itself is never driven to a pin. It can only be seen where the configuration window closes and where the later resets are timed.

On the same edge that recognises the external release, the block latches a set of configuration straps into a register. One strap selects whether the reference rate is the input clock or half of it. That choice sets the length of every phase after the internal reset, in input-clock cycles. While the PLL wait runs, an output marks the window in which a host may write configuration.

Top module: `por_seq`

## Requirements
- R1: While the synchronised external reset is low, all reset outputs are driven low, the window output is driven high and the strap register reads zero. This takes effect within 3 rising edges of the pin falling.
- R2: A low pulse on the pin counts as a valid reset when the pin is low for at least 16 rising clock edges. Its release starts the sequence, so exactly 16 edges is sufficient.
- R3: A low pulse shorter than 16 edges, for example 15, does not start a sequence. After it, every reset output stays low, the window stays closed and the strap register stays zero.
- R4: The internal power-on reset output rises on the 1027th rising edge after the pin goes high. This is 1024 counted cycles plus 3 edges of synchroniser and detection latency.
- R5: The straps are latched on the edge that recognises the release and ignored afterwards. Layout of straps_i and straps_o: bit 14 is reference divide-by-two; bit 13 watchdog enable; bit 12 64-bit mode; bit 11 sync mode; bit 10 config select; bit 9 config source; bits 8:7 clock mode; bits 6:4 bus mode; bits 3:0 chip identifier.
- R6: With strap bit 14 at 0, a reference cycle is one input clock. With bit 14 at 1, a reference cycle is two input clocks.
- R7: The window output goes low on the same edge as the internal reset release. It goes high again at lock, which comes 6400 reference cycles later, that is 6400 or 12800 input clocks.
- R8: The hard reset output rises 512 reference cycles after lock.
- R9: The soft reset output rises 515 reference cycles after lock, 3 reference cycles after the hard reset. The release order is always internal, then hard, then soft.
- R10: A valid reset asserted during any phase forces everything back to the R1 state. The next release restarts the full sequence with freshly latched straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| por_n_i | input | 1 | External power-on reset, active low, asynchronous |
| straps_i | input | 15 | Configuration strap pins, layout in R5 |
| int_por_n_o | output | 1 | Internal power-on reset, active low |
| hrst_n_o | output | 1 | Hard reset, active low |
| srst_n_o | output | 1 | Soft reset, active low |
| cfg_win_n_o | output | 1 | Host configuration window, low while open |
| straps_o | output | 15 | Latched strap register |

## Verification
The hardest case to reach from the ports is a valid reset that lands in the middle of the PLL-lock wait. There the divided reference phase and the shared counter both hold live state, and the window is open. The stimulus releases a divide-by-two sequence, waits until the window has been open for some thousands of cycles, then applies a fresh valid reset with a different strap pattern and a divide-by-one rate. It then checks that the forced state holds and that the following sequence is timed entirely from the new straps. Pulse widths of 15 and 16 edges sit on either side of the qualification limit.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

   typedef enum logic [2:0] {
      ST_HOLD,
      ST_INT,
      ST_LOCK,
      ST_POST,
      ST_DONE
   } seq_st_e;

   // Strap register layout, most significant field first
   typedef struct packed {
      logic       ref_div2;
      logic       wdog_en;
      logic       wide64;
      logic       sync_mode;
      logic       cfg_sel;
      logic       cfg_src;
      logic [1:0] clk_mode;
      logic [2:0] bus_mode;
      logic [3:0] chip_id;
   } strap_t;

   localparam int STRAP_W = $bits(strap_t);

endpackage

// File: rtl/por_sync.sv
module por_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad
         $error("por_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk_i) chain_q <= d_i;
      end else begin : g_many
         always_ff @(posedge clk_i) chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/por_pulse_qual.sv
module por_pulse_qual #(
   parameter int MIN_LOW = 16
) (
   input  logic clk_i,
   input  logic lvl_n_i,
   output logic start_o
);

   localparam int CW = $clog2(MIN_LOW + 1);

   logic [CW-1:0] low_cnt_q;

   generate
      if (MIN_LOW < 1) begin : g_bad
         $error("por_pulse_qual: MIN_LOW must be at least 1");
      end
   endgenerate

   // Saturating count of low cycles; cleared on the first high cycle
   always_ff @(posedge clk_i) begin
      if (!lvl_n_i) begin
         if (low_cnt_q != CW'(MIN_LOW)) low_cnt_q <= low_cnt_q + 1'b1;
      end else begin
         low_cnt_q <= '0;
      end
   end

   assign start_o = lvl_n_i && (low_cnt_q == CW'(MIN_LOW));

   // R2: a qualified release produces exactly one start request
   p_start_single_r2: assert property (@(posedge clk_i) disable iff (!lvl_n_i)
      start_o |=> !start_o);

endmodule

// File: rtl/por_ref_en.sv
module por_ref_en #(
   parameter bit ALLOW_DIV2 = 1'b1
) (
   input  logic clk_i,
   input  logic run_i,
   input  logic div2_i,
   output logic en_o
);

   generate
      if (ALLOW_DIV2) begin : g_div
         logic ph_q;
         always_ff @(posedge clk_i) begin
            if (!run_i) ph_q <= 1'b0;
            else        ph_q <= ~ph_q;
         end
         assign en_o = run_i && (!div2_i || ph_q);

         // R6: at half rate no two consecutive reference enables
         p_half_rate_r6: assert property (@(posedge clk_i) disable iff (!run_i)
            (div2_i && en_o) |=> !en_o);
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = div2_i;
         assign en_o       = run_i;
      end
   endgenerate

endmodule

// File: rtl/por_seq.sv
module por_seq
   import por_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 16,
   parameter int INT_CYC     = 1024,
   parameter int LOCK_CYC    = 6400,
   parameter int HARD_CYC    = 512,
   parameter int SOFT_CYC    = 515,
   parameter bit ALLOW_DIV2  = 1'b1
) (
   input  logic               clk_i,
   input  logic               por_n_i,
   input  logic [STRAP_W-1:0] straps_i,
   output logic               int_por_n_o,
   output logic               hrst_n_o,
   output logic               srst_n_o,
   output logic               cfg_win_n_o,
   output logic [STRAP_W-1:0] straps_o
);

   localparam int MAX_AB = (INT_CYC > LOCK_CYC) ? INT_CYC : LOCK_CYC;
   localparam int MAXC   = (MAX_AB > SOFT_CYC) ? MAX_AB : SOFT_CYC;
   localparam int CW     = $clog2(MAXC + 1);

   generate
      if (SOFT_CYC <= HARD_CYC) begin : g_bad_order
         $error("por_seq: SOFT_CYC must exceed HARD_CYC");
      end
      if (INT_CYC < 1 || LOCK_CYC < 1 || HARD_CYC < 1) begin : g_bad_len
         $error("por_seq: phase lengths must be at least 1");
      end
   endgenerate

   logic          lvl_n;
   logic          start;
   logic          ref_en;
   logic          run;
   seq_st_e       st_q;
   logic [CW-1:0] cnt_q;
   strap_t        cap;

   por_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .d_i   (por_n_i),
      .q_o   (lvl_n)
   );

   por_pulse_qual #(.MIN_LOW(MIN_LOW)) u_qual (
      .clk_i   (clk_i),
      .lvl_n_i (lvl_n),
      .start_o (start)
   );

   assign cap = strap_t'(straps_o);
   assign run = (st_q == ST_LOCK) || (st_q == ST_POST);

   por_ref_en #(.ALLOW_DIV2(ALLOW_DIV2)) u_ref (
      .clk_i  (clk_i),
      .run_i  (run),
      .div2_i (cap.ref_div2),
      .en_o   (ref_en)
   );

   always_ff @(posedge clk_i) begin
      if (!lvl_n) begin
         st_q        <= ST_HOLD;
         cnt_q       <= '0;
         int_por_n_o <= 1'b0;
         hrst_n_o    <= 1'b0;
         srst_n_o    <= 1'b0;
         cfg_win_n_o <= 1'b1;
         straps_o    <= '0;
      end else begin
         unique case (st_q)
            ST_HOLD: begin
               if (start) begin
                  st_q     <= ST_INT;
                  cnt_q    <= '0;
                  straps_o <= straps_i;
               end
            end
            ST_INT: begin
               if (cnt_q == CW'(INT_CYC - 1)) begin
                  st_q        <= ST_LOCK;
                  cnt_q       <= '0;
                  int_por_n_o <= 1'b1;
                  cfg_win_n_o <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_LOCK: begin
               if (ref_en) begin
                  if (cnt_q == CW'(LOCK_CYC - 1)) begin
                     st_q        <= ST_POST;
                     cnt_q       <= '0;
                     cfg_win_n_o <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_POST: begin
               if (ref_en) begin
                  if (cnt_q == CW'(HARD_CYC - 1)) hrst_n_o <= 1'b1;
                  if (cnt_q == CW'(SOFT_CYC - 1)) begin
                     srst_n_o <= 1'b1;
                     st_q     <= ST_DONE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R9: release order internal -> hard -> soft
   p_hard_after_int_r9: assert property (@(posedge clk_i) disable iff (!lvl_n)
      hrst_n_o |-> int_por_n_o);
   p_soft_after_hard_r9: assert property (@(posedge clk_i) disable iff (!lvl_n)
      srst_n_o |-> hrst_n_o);
   p_hard_first_r9: assert property (@(posedge clk_i) disable iff (!lvl_n)
      $rose(hrst_n_o) |-> !srst_n_o);
   // R7: window opens with the internal release, closes before hard release
   p_win_open_r7: assert property (@(posedge clk_i) disable iff (!lvl_n)
      $fell(cfg_win_n_o) |-> $rose(int_por_n_o));
   p_win_close_r7: assert property (@(posedge clk_i) disable iff (!lvl_n)
      $rose(cfg_win_n_o) |-> (int_por_n_o && !hrst_n_o));
   // R5: latched straps never move once the internal reset is released
   p_straps_hold_r5: assert property (@(posedge clk_i) disable iff (!lvl_n)
      int_por_n_o |-> $stable(straps_o));

endmodule

// File: tb/sim_por_seq.sv
`timescale 1ns/1ps
module sim_por_seq;
   import por_seq_pkg::*;

   localparam int LAT      = 3;
   localparam int INT_CYC  = 1024;
   localparam int LOCK_CYC = 6400;
   localparam int HARD_CYC = 512;
   localparam int SOFT_CYC = 515;
   localparam int WDOG     = 190000;

   logic               clk = 1'b0;
   logic               por_n;
   logic [STRAP_W-1:0] straps;
   logic               int_n, hr_n, sr_n, win_n;
   logic [STRAP_W-1:0] straps_q;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int rel   = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   por_seq u0 (
      .clk_i       (clk),
      .por_n_i     (por_n),
      .straps_i    (straps),
      .int_por_n_o (int_n),
      .hrst_n_o    (hr_n),
      .srst_n_o    (sr_n),
      .cfg_win_n_o (win_n),
      .straps_o    (straps_q)
   );

   always @(posedge clk) begin
      if (cyc == WDOG) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_forced(input string req);
      chk(req, "int_por_n low", int_n, 0);
      chk(req, "hrst_n low", hr_n, 0);
      chk(req, "srst_n low", sr_n, 0);
      chk(req, "window closed", win_n, 1);
      chk(req, "straps cleared", straps_q, 0);
   endtask

   // Low pulse of w rising edges; checks the forced state just before release
   task automatic pulse(input int w, input logic [STRAP_W-1:0] pat);
      @(negedge clk);
      por_n  = 1'b0;
      straps = pat;
      repeat (w) @(posedge clk);
      @(negedge clk);
      if (w >= LAT + 1) chk_forced("R1");
      por_n = 1'b1;
      rel   = cyc;
   endtask

   // Follow a started sequence and check every release time
   task automatic run_seq(input int div, input logic [STRAP_W-1:0] pat, input string tag);
      int t_int = -1, t_wo = -1, t_wc = -1, t_h = -1, t_s = -1;
      int lock;
      for (int k = 0; k < 20000 && t_s < 0; k++) begin
         @(negedge clk);
         if (cyc - rel == 6) straps = ~pat;
         if (t_int < 0 && int_n) t_int = cyc - rel;
         if (t_wo < 0 && !win_n) t_wo = cyc - rel;
         if (t_wo >= 0 && t_wc < 0 && win_n) t_wc = cyc - rel;
         if (t_h < 0 && hr_n) t_h = cyc - rel;
         if (t_s < 0 && sr_n) t_s = cyc - rel;
      end
      lock = INT_CYC + LAT + div * LOCK_CYC;
      $display("sequence %s div=%0d", tag, div);
      chk("R4", "internal release edge", t_int, INT_CYC + LAT);
      chk("R7", "window open edge", t_wo, INT_CYC + LAT);
      chk("R6", "lock (window close) edge", t_wc, lock);
      chk("R8", "hard release edge", t_h, lock + div * HARD_CYC);
      chk("R9", "soft release edge", t_s, lock + div * SOFT_CYC);
      chk("R5", "latched straps", straps_q, pat);
   endtask

   task automatic t_reset();
      por_n  = 1'b0;
      straps = '0;
      repeat (40) @(negedge clk);
      chk_forced("R1");
   endtask

   task automatic t_div1();
      pulse(40, 15'h2A5C);
      run_seq(1, 15'h2A5C, "div1");
   endtask

   task automatic t_div2();
      pulse(40, 15'h4C3B);
      run_seq(2, 15'h4C3B, "div2");
   endtask

   task automatic t_short();
      pulse(10, 15'h1E71);
      repeat (2000) @(negedge clk);
      chk("R3", "no restart after 10-edge pulse", {int_n, hr_n, sr_n, win_n}, 4'b0001);
      chk("R3", "straps not captured", straps_q, 0);
      pulse(15, 15'h1E71);
      repeat (2000) @(negedge clk);
      chk("R3", "no restart after 15-edge pulse", {int_n, hr_n, sr_n, win_n}, 4'b0001);
      pulse(16, 15'h1E71);
      run_seq(1, 15'h1E71, "16-edge pulse R2");
   endtask

   task automatic t_abort();
      pulse(20, 15'h4C3B);
      repeat (3000) @(negedge clk);
      chk("R10", "window open mid-lock", win_n, 0);
      chk("R10", "internal released mid-lock", int_n, 1);
      pulse(20, 15'h0B96);
      run_seq(1, 15'h0B96, "restart R10");
   endtask

   initial begin
      t_reset();
      t_div1();
      t_div2();
      t_short();
      t_abort();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule